// File: doc/BRIEF.md
# Hotplug Event Interrupt Aggregator

This block collects the events of a group of hotplug slots and turns them into one interrupt. Each slot keeps a five-bit record of the events that have happened on it, and beside it a seven-bit mask byte. Slot logic and the command engine set the event bits with single-cycle pulses. Software clears them by writing ones. Any slot whose recorded events are not all masked raises its own bit in a locator word. Bit 0 of that word reports a finished command, unless command interrupts are masked.

A global control word holds four disable bits and two sticky detection flags: command finished and arbiter error. In level mode the interrupt output follows the locator word, gated by the global interrupt disable. In message mode the level pin stays low. Instead, a single-cycle message request is issued each time the computed level differs from the level last signalled.

Software reaches the registers through a word-wide write port with byte enables and a combinational read port. The control word sits at address 0, and slot s sits at address s+1.

Top module: `hp_event_irq`

## Requirements
- R1: After reset, every slot's event bits read 0 and its mask byte reads 0x7F. The control word reads 0x0000000F. The locator, `irq` and `msi_req` are all 0.
- R2: A pulse on `evt_set[5*s+b]` sets event bit b of slot s at the next clock edge. The event bits are 0 = presence, 1 = isolated fault, 2 = button, 3 = latch lever, 4 = connected fault. They are read back at bits [4:0] of the slot word.
- R3: A write to a slot word with `wr_be[0]` set clears every event bit whose data bit [4:0] is 1. Data bits that are 0, or a write with `wr_be[0]` clear, leave the event bits unchanged.
- R4: If a hardware set and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R5: The slot mask byte sits at bits [14:8] of the slot word and is written when `wr_be[1]` is set. Mask bits [4:0] mask the matching events. Mask bits 5 and 6 are stored but do not affect the locator.
- R6: Locator bit s+1 is 1 when slot s has an event bit set whose mask bit is clear. The locator changes at the clock edge after the edge that changed the slot state.
- R7: Locator bit 0 is 1 when the command-finished flag (control bit 16) is 1 and the command interrupt disable (control bit 2) is 0. It follows the same one-edge delay as R6.
- R8: In level mode (`msi_mode` = 0), `irq` is 1 when the global interrupt disable (control bit 0) is 0 and the locator is nonzero. It is registered with the locator.
- R9: Control bits [3:0] are written when `wr_be[0]` is set. Flags 16 (command finished) and 17 (arbiter error) are set by pulses on `cmd_done` and `arb_err`. They are cleared by writing 1 with `wr_be[2]` set, and a set in the same cycle wins over the clear.
- R10: In message mode, `irq` stays 0. `msi_req` pulses for one cycle, in the cycle the locator updates, whenever the new level differs in either direction from the level last signalled. The last-signalled level is tracked in both modes and is 0 after reset.
- R11: Writes to addresses above NUM_SLOTS change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | 1 selects message signalling, 0 selects level |
| evt_set | input | NUM_SLOTS*5 | Per-slot event set pulses, five bits per slot |
| cmd_done | input | 1 | Pulse from the command engine when a command finishes |
| arb_err | input | 1 | Pulse on an arbiter error |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 is control, s+1 is slot s |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| locator | output | NUM_SLOTS+1 | Registered locator word |
| irq | output | 1 | Registered level interrupt |
| msi_req | output | 1 | Single-cycle message request |

## Verification
The bench drives a hardware set and a write-one clear into the same bit in the same cycle. A design that lets the clear win would lose an event, and the readback would show the bit as 0. It checks the locator both one edge and two edges after an event. A design without the register stage, or with an extra one, would show the bit too early or too late. It also checks that mask bits 5 and 6 alone do not hide a slot, and that a write without the right byte enable leaves the masks and flags alone.

In message mode the bench watches for exactly one request on the rising level and one on the falling level. It then switches from level to message mode while the level is already high. A design that did not track the last-signalled level in level mode would send a spurious request at that point.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;

  localparam int EVT_W        = 5;
  localparam int DIS_W        = 7;
  localparam int CTL_W        = 4;
  localparam int SLOT_EVT_LSB = 0;
  localparam int SLOT_DIS_LSB = 8;
  localparam int CTL_GINT_DIS = 0;
  localparam int CTL_CMD_DIS  = 2;
  localparam int FLAG_CMD_BIT = 16;
  localparam int FLAG_ARB_BIT = 17;

  localparam logic [DIS_W-1:0] DIS_RESET = '1;
  localparam logic [CTL_W-1:0] CTL_RESET = '1;

  // A sticky bit keeps its value, loses it when cleared, and is always set by a set.
  function automatic logic [EVT_W-1:0] sticky_merge(logic [EVT_W-1:0] cur,
                                                    logic [EVT_W-1:0] set,
                                                    logic [EVT_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic slot_pending(logic [EVT_W-1:0] evt, logic [DIS_W-1:0] dis);
    return |(evt & ~dis[EVT_W-1:0]);
  endfunction

  function automatic logic irq_level(logic [31:0] loc, logic gint_dis);
    return !gint_dis && (loc != 32'd0);
  endfunction

  function automatic logic [31:0] slot_word(logic [EVT_W-1:0] evt, logic [DIS_W-1:0] dis);
    logic [31:0] w;
    w = '0;
    w[SLOT_EVT_LSB +: EVT_W] = evt;
    w[SLOT_DIS_LSB +: DIS_W] = dis;
    return w;
  endfunction

  function automatic logic [31:0] ctrl_word(logic [CTL_W-1:0] ctl, logic cmd, logic arb);
    logic [31:0] w;
    w = '0;
    w[CTL_W-1:0]   = ctl;
    w[FLAG_CMD_BIT] = cmd;
    w[FLAG_ARB_BIT] = arb;
    return w;
  endfunction

endpackage

// File: rtl/hp_evt_slot.sv
module hp_evt_slot
  import hp_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set,
  input  logic             wr_hit,
  input  logic             be_evt,
  input  logic             be_dis,
  input  logic [EVT_W-1:0] wr_evt,
  input  logic [DIS_W-1:0] wr_dis,
  output logic [EVT_W-1:0] evt_q,
  output logic [DIS_W-1:0] dis_q,
  output logic             pending
);

  logic [EVT_W-1:0] sw_clr;
  logic             dis_wr;

  assign sw_clr = (wr_hit && be_evt) ? wr_evt : '0;
  assign dis_wr = wr_hit && be_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      dis_q <= DIS_RESET;
    end else begin
      evt_q <= sticky_merge(evt_q, evt_set, sw_clr);
      if (dis_wr) dis_q <= wr_dis;
    end
  end

  assign pending = slot_pending(evt_q, dis_q);

  // R2 and R4: every pulsed event bit is set one edge later, clear or not
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  // R3: bits written as one without a concurrent set are gone one edge later
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && be_evt) |=> ((evt_q & $past(wr_evt) & ~$past(evt_set)) == '0));

  // R5: the mask byte only moves on an enabled write
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_wr |=> $stable(dis_q));

endmodule

// File: rtl/hp_evt_ctrl.sv
module hp_evt_ctrl
  import hp_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_done,
  input  logic             arb_err,
  input  logic             wr_hit,
  input  logic             be_ctl,
  input  logic             be_flag,
  input  logic [CTL_W-1:0] wr_ctl,
  input  logic [1:0]       wr_flag_clr,
  output logic [CTL_W-1:0] ctl_q,
  output logic             cmd_det_q,
  output logic             arb_det_q,
  output logic             cmd_pend
);

  logic       ctl_wr;
  logic [1:0] flag_clr;

  assign ctl_wr   = wr_hit && be_ctl;
  assign flag_clr = (wr_hit && be_flag) ? wr_flag_clr : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= CTL_RESET;
      cmd_det_q <= 1'b0;
      arb_det_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= wr_ctl;
      cmd_det_q <= (cmd_det_q && !flag_clr[0]) || cmd_done;
      arb_det_q <= (arb_det_q && !flag_clr[1]) || arb_err;
    end
  end

  assign cmd_pend = cmd_det_q && !ctl_q[CTL_CMD_DIS];

  // R9: a finished command always leaves the flag set
  assert_cmd_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> cmd_det_q);

  // R9: an arbiter error always leaves its flag set
  assert_arb_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_err |=> arb_det_q);

  // R9: the disable bits only move on an enabled write
  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_q));

endmodule

// File: rtl/hp_evt_signal.sv
module hp_evt_signal
  import hp_evt_pkg::*;
#(
  parameter int NSL = 4,
  localparam int LOC_W = NSL + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSL-1:0]   slot_pend,
  input  logic             cmd_pend,
  input  logic             gint_dis,
  input  logic             msi_mode,
  output logic [LOC_W-1:0] locator_q,
  output logic             irq_q,
  output logic             msi_pulse_q
);

  logic [LOC_W-1:0] loc_c;
  logic             lvl_c;
  logic             last_sig_q;
  logic             lvl_changed;

  assign loc_c       = {slot_pend, cmd_pend};
  assign lvl_c       = irq_level(32'(loc_c), gint_dis);
  assign lvl_changed = lvl_c != last_sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locator_q   <= '0;
      irq_q       <= 1'b0;
      msi_pulse_q <= 1'b0;
      last_sig_q  <= 1'b0;
    end else begin
      locator_q   <= loc_c;
      irq_q       <= lvl_c && !msi_mode;
      msi_pulse_q <= msi_mode && lvl_changed;
      last_sig_q  <= lvl_c;
    end
  end

  // R6: a pending slot shows in the slot part of the locator one edge later
  assert_loc_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pend != '0) |=> (locator_q[LOC_W-1:1] != '0));

  // R7: a pending command shows in locator bit 0 one edge later
  assert_cmd_loc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pend |=> locator_q[0]);

  // R8: the level never rises with an empty locator
  assert_irq_needs_loc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (locator_q != '0));

  // R10: message mode keeps the level pin low
  assert_msi_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(msi_mode) |-> !irq_q);

  // R10: a message request only follows a cycle in message mode
  assert_msi_only_in_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse_q |-> $past(msi_mode));

endmodule

// File: rtl/hp_event_irq.sv
module hp_event_irq
  import hp_evt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       msi_mode,
  input  logic [NUM_SLOTS*EVT_W-1:0] evt_set,
  input  logic                       cmd_done,
  input  logic                       arb_err,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [3:0]                 wr_be,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [31:0]                rd_data,
  output logic [NUM_SLOTS:0]         locator,
  output logic                       irq,
  output logic                       msi_req
);

  logic [EVT_W-1:0] evt_q   [NUM_SLOTS];
  logic [DIS_W-1:0] dis_q   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_pend;
  logic [CTL_W-1:0] ctl_q;
  logic             cmd_det_q;
  logic             arb_det_q;
  logic             cmd_pend;
  logic             ctl_hit;

  assign ctl_hit = wr_en && (wr_addr == '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic slot_hit;
    assign slot_hit = wr_en && (wr_addr == ADDR_W'(s + 1));

    hp_evt_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_set (evt_set[s*EVT_W +: EVT_W]),
      .wr_hit  (slot_hit),
      .be_evt  (wr_be[0]),
      .be_dis  (wr_be[1]),
      .wr_evt  (wr_data[SLOT_EVT_LSB +: EVT_W]),
      .wr_dis  (wr_data[SLOT_DIS_LSB +: DIS_W]),
      .evt_q   (evt_q[s]),
      .dis_q   (dis_q[s]),
      .pending (slot_pend[s])
    );
  end

  hp_evt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_done    (cmd_done),
    .arb_err     (arb_err),
    .wr_hit      (ctl_hit),
    .be_ctl      (wr_be[0]),
    .be_flag     (wr_be[2]),
    .wr_ctl      (wr_data[CTL_W-1:0]),
    .wr_flag_clr (wr_data[FLAG_ARB_BIT:FLAG_CMD_BIT]),
    .ctl_q       (ctl_q),
    .cmd_det_q   (cmd_det_q),
    .arb_det_q   (arb_det_q),
    .cmd_pend    (cmd_pend)
  );

  hp_evt_signal #(.NSL(NUM_SLOTS)) u_signal (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_pend   (slot_pend),
    .cmd_pend    (cmd_pend),
    .gint_dis    (ctl_q[CTL_GINT_DIS]),
    .msi_mode    (msi_mode),
    .locator_q   (locator),
    .irq_q       (irq),
    .msi_pulse_q (msi_req)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = ctrl_word(ctl_q, cmd_det_q, arb_det_q);
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_addr == ADDR_W'(s + 1)) rd_data = slot_word(evt_q[s], dis_q[s]);
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[31:18], wr_data[15], wr_data[7:5], wr_be[3]};

  // R11: a write outside the map leaves the command flag untouched unless a command finishes
  assert_out_of_map_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > ADDR_W'(NUM_SLOTS)) && !cmd_done) |=> ($stable(cmd_det_q) && $stable(ctl_q)));

endmodule

// File: tb/hp_event_irq_tb.sv
`timescale 1ns/1ps
module hp_event_irq_tb;
  localparam int NS = 4;
  localparam int AW = $clog2(NS + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msi_mode = 1'b0;
  logic [NS*5-1:0] evt_set = '0;
  logic cmd_done = 1'b0, arb_err = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] rd_data;
  logic [NS:0] locator;
  logic irq, msi_req;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hp_event_irq #(.NUM_SLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .evt_set(evt_set),
    .cmd_done(cmd_done), .arb_err(arb_err), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .locator(locator), .irq(irq), .msi_req(msi_req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; msi_mode = 1'b0; evt_set = '0; cmd_done = 1'b0; arb_err = 1'b0;
    wr_en = 1'b0; wr_data = '0; wr_be = '0;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic do_write(int addr, logic [31:0] data, logic [3:0] be);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data; wr_be = be;
    tick();
    wr_en = 1'b0; wr_data = '0; wr_be = '0;
  endtask

  task automatic pulse_evt(int slot, logic [4:0] bits);
    evt_set[slot*5 +: 5] = bits;
    tick();
    evt_set = '0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    rd_addr = AW'(addr);
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    apply_reset();
    rd(0, d); chk("R1 control word", d, 32'h0000_000F);
    rd(1, d); chk("R1 slot0 word", d, 32'h0000_7F00);
    rd(NS, d); chk("R1 last slot word", d, 32'h0000_7F00);
    chk("R1 locator", 32'(locator), 32'h0);
    chk("R1 irq/msi", {30'b0, irq, msi_req}, 32'h0);
  endtask

  task automatic t_event();
    logic [31:0] d;
    apply_reset();
    do_write(2, 32'h0, 4'b0010);
    pulse_evt(1, 5'b00100);
    rd(2, d); chk("R2 button latched slot1", d, 32'h0000_0004);
    chk("R6 locator not yet updated", 32'(locator), 32'h0);
    tick();
    chk("R6 locator slot1 bit2", 32'(locator), 32'h04);
    chk("R8 irq held by global disable", 32'(irq), 32'h0);
    pulse_evt(1, 5'b10000);
    rd(2, d); chk("R2 connected fault adds", d, 32'h0000_0014);
    do_write(0, 32'h0, 4'b0001);
    tick();
    chk("R8 irq raised", 32'(irq), 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    apply_reset();
    do_write(1, 32'h0, 4'b0010);
    pulse_evt(0, 5'b01001);
    do_write(1, 32'h0, 4'b0001);
    rd(1, d); chk("R3 zero write keeps bits", d, 32'h0000_0009);
    do_write(1, 32'h1, 4'b0001);
    rd(1, d); chk("R3 clear presence", d, 32'h0000_0008);
    do_write(1, 32'h8, 4'b0010);
    rd(1, d); chk("R3 no clear without byte0 enable", d, 32'h0000_0008);
    do_write(1, 32'h8, 4'b0001);
    rd(1, d); chk("R3 clear lever bit", d, 32'h0);
    tick();
    chk("R6 locator empties", 32'(locator), 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    apply_reset();
    evt_set[2*5 +: 5] = 5'b00010;
    wr_en = 1'b1; wr_addr = AW'(3); wr_data = 32'h2; wr_be = 4'b0001;
    tick();
    evt_set = '0; wr_en = 1'b0; wr_data = '0; wr_be = '0;
    rd(3, d); chk("R4 set beats clear", d, 32'h0000_7F02);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    apply_reset();
    pulse_evt(0, 5'b00001);
    tick();
    chk("R6 masked event hidden", 32'(locator), 32'h0);
    do_write(1, 32'h0000_6000, 4'b0010);
    rd(1, d); chk("R5 mask readback", d, 32'h0000_6001);
    tick();
    chk("R5 bits 5,6 do not mask", 32'(locator), 32'h02);
    do_write(1, 32'h0000_0100, 4'b0010);
    tick();
    chk("R5 presence mask hides slot", 32'(locator), 32'h0);
  endtask

  task automatic t_multi();
    apply_reset();
    do_write(1, 32'h0, 4'b0010);
    do_write(NS, 32'h0, 4'b0010);
    evt_set[0 +: 5] = 5'b01000;
    evt_set[(NS-1)*5 +: 5] = 5'b10000;
    tick();
    evt_set = '0;
    tick();
    chk("R6 slots 0 and last", 32'(locator), 32'h12);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    apply_reset();
    cmd_done = 1'b1; tick(); cmd_done = 1'b0;
    rd(0, d); chk("R9 command flag set", d, 32'h0001_000F);
    tick();
    chk("R7 command masked", 32'(locator), 32'h0);
    do_write(0, 32'h0, 4'b0001);
    rd(0, d); chk("R9 disables written", d, 32'h0001_0000);
    tick();
    chk("R7 command locator bit", 32'(locator), 32'h1);
    chk("R8 irq from command", 32'(irq), 32'h1);
    do_write(0, 32'h0001_0000, 4'b0100);
    rd(0, d); chk("R9 command flag cleared", d, 32'h0);
    tick();
    chk("R7 locator clear", 32'(locator), 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);
    cmd_done = 1'b1;
    wr_en = 1'b1; wr_addr = '0; wr_data = 32'h0003_0000; wr_be = 4'b0100;
    tick();
    cmd_done = 1'b0; wr_en = 1'b0; wr_data = '0; wr_be = '0;
    rd(0, d); chk("R9 flag set beats clear", d, 32'h0001_0000);
    arb_err = 1'b1; tick(); arb_err = 1'b0;
    rd(0, d); chk("R9 arbiter flag set", d, 32'h0003_0000);
    do_write(0, 32'hFFFF_FFFF, 4'b1011);
    rd(0, d); chk("R9 flags need byte2 enable", d, 32'h0003_000F);
  endtask

  task automatic t_msi();
    apply_reset();
    msi_mode = 1'b1;
    do_write(0, 32'h0, 4'b0001);
    do_write(1, 32'h0, 4'b0010);
    tick();
    chk("R10 no request while idle", 32'(msi_req), 32'h0);
    pulse_evt(0, 5'b00001);
    chk("R10 no request before locator", 32'(msi_req), 32'h0);
    tick();
    chk("R10 request on rise", 32'(msi_req), 32'h1);
    chk("R10 level pin low", 32'(irq), 32'h0);
    tick();
    chk("R10 request one cycle", 32'(msi_req), 32'h0);
    pulse_evt(0, 5'b00010);
    tick();
    chk("R10 no request level unchanged", 32'(msi_req), 32'h0);
    do_write(1, 32'h3, 4'b0001);
    tick();
    chk("R10 request on fall", 32'(msi_req), 32'h1);
    tick();
    chk("R10 fall request one cycle", 32'(msi_req), 32'h0);
  endtask

  task automatic t_switch();
    apply_reset();
    do_write(0, 32'h0, 4'b0001);
    do_write(1, 32'h0, 4'b0010);
    pulse_evt(0, 5'b00100);
    tick();
    chk("R8 level mode irq", 32'(irq), 32'h1);
    msi_mode = 1'b1;
    tick();
    chk("R10 switch drops irq", 32'(irq), 32'h0);
    chk("R10 no request on switch", 32'(msi_req), 32'h0);
    tick();
    chk("R10 still no request", 32'(msi_req), 32'h0);
    msi_mode = 1'b0;
    tick();
    chk("R8 irq back in level mode", 32'(irq), 32'h1);
  endtask

  task automatic t_range();
    logic [31:0] d;
    apply_reset();
    do_write(NS + 1, 32'h0, 4'b1111);
    do_write((1 << AW) - 1, 32'h0, 4'b1111);
    rd(0, d); chk("R11 control intact", d, 32'h0000_000F);
    rd(NS, d); chk("R11 last slot intact", d, 32'h0000_7F00);
    rd(NS + 1, d); chk("R11 read beyond map", d, 32'h0);
    rd((1 << AW) - 1, d); chk("R11 read top address", d, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_event();
    t_w1c();
    t_set_wins();
    t_mask();
    t_multi();
    t_cmd();
    t_msi();
    t_switch();
    t_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule